// File: doc/BRIEF.md
# Counter On-Line Checker

This block sits next to a small up-counter and judges it on every rising clock edge. It samples the counter's asynchronous reset, its synchronous start input and its count output. From the samples taken at one edge it forms the value the counter must show at the next edge. When the counter breaks a rule, the checker raises a one-cycle pulse and sets an error flag that stays high. The rules are: a wrong value while counting, a nonzero value after reset, a value other than one after start, a value that changes while the counter waits for start, and reset and start asserted together.

The checker holds only a copy of the expected count, the rule that produced that copy, and a three-way mode (not yet synchronised, idle, counting). Its cost is therefore a handful of flops and one comparator, far below that of a generic property monitor. A reference counter with the same clock, reset and start ports is included so that the checker can be exercised. The checker has its own synchronous active-low reset, which is separate from the reset it observes.

Top module: `cnt_watch`

## Requirements
- R1: While counting, with neither observed reset nor start sampled at the previous edge, the count sampled at an edge must equal the count sampled at the previous edge plus one, modulo 2^W (after 15, 0 follows for W=4). Any other value makes err_pulse high after that edge.
- R2: If mon_rst was sampled high at an edge, the count sampled at the next edge must be 0. Otherwise err_pulse is high after that next edge.
- R3: If mon_start was sampled high and mon_rst low at an edge, the count sampled at the next edge must be 1. Otherwise err_pulse is high after that next edge.
- R4: After an observed reset and before the first start, the count must be 0 at every edge. A nonzero count makes err_pulse high after that edge.
- R5: When mon_rst and mon_start are both sampled high at the same edge, err_pulse is high after that edge.
- R6: err_flag is low while rst_n is low. It is set by any violation and then stays high until rst_n is sampled low.
- R7: err_pulse is high for exactly the one cycle after each edge at which a violation is detected, and err_flag is high whenever err_pulse is high.
- R8: At an edge where mon_rst is sampled high, the count is not compared, because the asynchronous reset may already have cleared it. After rst_n is released, no count is compared until the first observed reset or start has been sampled.
- R9: The reference counter clears to 0 at once when its reset is high, loads 1 at an edge where start is high, and afterwards increments by one at each edge, wrapping from 15 to 0. Before the first start it holds its value.
- R10: A fault-free reference counter driven through reset, idle, start, wrap-around and a reset in mid-count never makes err_pulse or err_flag high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the observed counter |
| rst_n | input | 1 | Synchronous active-low reset of the checker itself |
| mon_rst | input | 1 | Observed counter reset, active high |
| mon_start | input | 1 | Observed counter start, active high |
| mon_count | input | W | Observed counter output |
| err_flag | output | 1 | Sticky error indication, cleared only by rst_n |
| err_pulse | output | 1 | One-cycle mark of the edge at which a violation was seen |

## Verification
Two functions can fall in the same cycle: the overlap rule, and the reset rule together with its suspended comparison. The overlap case is provoked by raising the observed reset and start together between edges, so that the counter is already cleared when the edge samples them. At that edge the bench expects a pulse from the overlap rule alone. At the following edge it expects no pulse, because the reset took precedence and 0 is the correct value. The flag must stay high until the checker's own reset clears it.

// File: rtl/cnt_watch_pkg.sv
`timescale 1ns/1ps
// Shared types of the counter checker.
// Assumes: none beyond a single clock domain.
package cnt_watch_pkg;

    // Tracking mode of the observed counter
    typedef enum logic [1:0] {
        MODE_UNSYNC = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_COUNT  = 2'd2
    } mode_e;

    // Which rule produced the current expectation
    typedef enum logic [2:0] {
        RULE_NONE  = 3'd0,
        RULE_RST   = 3'd1,
        RULE_START = 3'd2,
        RULE_SEQ   = 3'd3,
        RULE_IDLE  = 3'd4
    } rule_e;

    // One bit per broken rule
    typedef struct packed {
        logic seq_bad;
        logic after_rst_bad;
        logic after_start_bad;
        logic idle_moved;
        logic overlap;
    } viol_t;

endpackage

// File: rtl/cnt_ref.sv
`timescale 1ns/1ps
// Reference up-counter used to exercise the checker.
// The reset is asynchronous and active high, and it clears the count at once.
// Start loads 1, and counting continues with wrap-around after start.
// Assumes: start and reset are changed away from the clock edge.
module cnt_ref #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic [W-1:0] count
);

    logic running;

    // Count register with asynchronous clear and start-gated increment
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (start) begin
            count   <= W'(1);
            running <= 1'b1;
        end else if (running) begin
            count   <= count + W'(1);
        end
    end

endmodule

// File: rtl/cnt_watch_track.sv
`timescale 1ns/1ps
// Expectation tracker: follows the mode of the observed counter.
// From the samples of one edge it forms the value due at the next edge.
// Reset has priority over start, and start has priority over counting.
// While counting, the expectation comes from the observed count, so one
// bad value is reported once.
// Assumes: rst_n is synchronous and active low.
module cnt_watch_track
    import cnt_watch_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mon_rst,
    input  logic         mon_start,
    input  logic [W-1:0] mon_count,
    output rule_e        rule_q,
    output logic [W-1:0] exp_q
);

    mode_e        mode_q;
    mode_e        mode_d;
    rule_e        rule_d;
    logic [W-1:0] exp_d;

    // Next mode, next rule and next expected value
    always_comb begin
        mode_d = mode_q;
        rule_d = RULE_NONE;
        exp_d  = '0;
        if (mon_rst) begin
            mode_d = MODE_IDLE;
            rule_d = RULE_RST;
        end else if (mon_start) begin
            mode_d = MODE_COUNT;
            rule_d = RULE_START;
            exp_d  = W'(1);
        end else begin
            case (mode_q)
                MODE_COUNT: begin
                    rule_d = RULE_SEQ;
                    exp_d  = mon_count + W'(1);
                end
                MODE_IDLE: rule_d = RULE_IDLE;
                default:   rule_d = RULE_NONE;
            endcase
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_UNSYNC;
            rule_q <= RULE_NONE;
            exp_q  <= '0;
        end else begin
            mode_q <= mode_d;
            rule_q <= rule_d;
            exp_q  <= exp_d;
        end
    end

    // R4: a sampled reset must leave the tracker expecting zero
    a_r4_idle_expect: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_rst) |=> (exp_q == '0));

endmodule

// File: rtl/cnt_watch_judge.sv
`timescale 1ns/1ps
// Rule judge: compares the observed count with the expectation and
// classifies each violation by the rule that set the expectation.
// Comparison is suspended while the observed reset is high.
// Assumes: inputs are sampled on the same edge as the tracker.
module cnt_watch_judge
    import cnt_watch_pkg::*;
#(
    parameter int W = 4
) (
    input  rule_e        rule_q,
    input  logic [W-1:0] exp_q,
    input  logic         mon_rst,
    input  logic         mon_start,
    input  logic [W-1:0] mon_count,
    output viol_t        viol,
    output logic         hit
);

    logic mismatch;

    // Per-rule violation decode
    always_comb begin
        mismatch             = (mon_count != exp_q) && !mon_rst;
        viol.seq_bad         = mismatch && (rule_q == RULE_SEQ);
        viol.after_rst_bad   = mismatch && (rule_q == RULE_RST);
        viol.after_start_bad = mismatch && (rule_q == RULE_START);
        viol.idle_moved      = mismatch && (rule_q == RULE_IDLE);
        viol.overlap         = mon_rst && mon_start;
        hit                  = |viol;
    end

endmodule

// File: rtl/cnt_watch_latch.sv
`timescale 1ns/1ps
// Error latch: registers the one-cycle pulse and the sticky flag.
// Assumes: rst_n is synchronous and active low, and it alone clears the flag.
module cnt_watch_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic err_flag,
    output logic err_pulse
);

    // Pulse follows each detection, flag accumulates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            err_pulse <= hit;
            err_flag  <= err_flag | hit;
        end
    end

    // R6: flag is sticky until the checker reset
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R7: pulse never appears without the flag
    a_r7_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_flag);

endmodule

// File: rtl/cnt_watch.sv
`timescale 1ns/1ps
// On-line checker for a start-gated up-counter of W bits.
// It checks the values after reset and after start, the increment while
// counting, zero while idle, and flags reset and start asserted together.
// Assumes: the observed inputs are stable around the rising edge of clk.
module cnt_watch
    import cnt_watch_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mon_rst,
    input  logic         mon_start,
    input  logic [W-1:0] mon_count,
    output logic         err_flag,
    output logic         err_pulse
);

    rule_e        rule_q;
    logic [W-1:0] exp_q;
    viol_t        viol;
    logic         hit;

    cnt_watch_track #(.W(W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_rst   (mon_rst),
        .mon_start (mon_start),
        .mon_count (mon_count),
        .rule_q    (rule_q),
        .exp_q     (exp_q)
    );

    cnt_watch_judge #(.W(W)) u_judge (
        .rule_q    (rule_q),
        .exp_q     (exp_q),
        .mon_rst   (mon_rst),
        .mon_start (mon_start),
        .mon_count (mon_count),
        .viol      (viol),
        .hit       (hit)
    );

    cnt_watch_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .err_flag  (err_flag),
        .err_pulse (err_pulse)
    );

    // R2: a nonzero count after a sampled reset is reported
    a_r2_rst_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mon_rst) && !mon_rst && (mon_count != '0))
        |=> err_pulse);

    // R3: a count other than one after a sampled start is reported
    a_r3_start_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mon_start) && !$past(mon_rst) && !mon_rst
         && (mon_count != W'(1)))
        |=> err_pulse);

    // R5: reset together with start is reported
    a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_rst && mon_start) |=> err_pulse);

endmodule

// File: tb/cnt_watch_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module cnt_watch_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         c_rst = 1'b1;
    logic         c_start = 1'b0;
    logic         r_rst = 1'b1;
    logic         r_start = 1'b0;
    logic         ovr_en = 1'b0;
    logic [W-1:0] ovr_val = '0;
    logic [W-1:0] stuck = '0;
    logic [W-1:0] r_count;
    logic [W-1:0] obs;
    logic         err_flag;
    logic         err_pulse;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    assign obs = ovr_en ? ovr_val : (r_count | stuck);

    cnt_ref #(.W(W)) u_ref (
        .clk   (clk),
        .rst   (r_rst),
        .start (r_start),
        .count (r_count)
    );

    cnt_watch #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_rst   (c_rst),
        .mon_start (c_start),
        .mon_count (obs),
        .err_flag  (err_flag),
        .err_pulse (err_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_both(input logic rs, input logic st);
        c_rst = rs; r_rst = rs; c_start = st; r_start = st;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; set_both(1'b1, 1'b0); ovr_en = 1'b0; stuck = '0;
        tick(); tick();
        check("R6 flag low in reset", int'(err_flag), 0);
        rst_n = 1'b1;
        tick();
        set_both(1'b0, 1'b0);
        tick();
    endtask

    task automatic t_fault_free();
        int e;
        do_reset();
        repeat (3) begin
            tick();
            check("R4 idle no pulse", int'(err_pulse), 0);
            check("R9 idle holds zero", int'(r_count), 0);
        end
        set_both(1'b0, 1'b1); tick(); set_both(1'b0, 1'b0);
        e = 1;
        check("R9 start loads one", int'(r_count), 1);
        for (int i = 0; i < 20; i++) begin
            tick();
            e = (e + 1) % 16;
            check("R9 increment/wrap", int'(r_count), e);
            check("R1 good sequence no pulse", int'(err_pulse), 0);
        end
        set_both(1'b1, 1'b0);
        #1;
        check("R9 async clear", int'(r_count), 0);
        tick();
        check("R8 suspended compare", int'(err_pulse), 0);
        set_both(1'b0, 1'b0);
        tick();
        check("R2 good reset no pulse", int'(err_pulse), 0);
        check("R10 fault-free no flag", int'(err_flag), 0);
    endtask

    task automatic t_stuck_bit();
        do_reset();
        set_both(1'b0, 1'b1); tick(); set_both(1'b0, 1'b0);
        tick();
        stuck = 4'b0100;
        tick();
        check("R1 stuck bit pulse", int'(err_pulse), 1);
        stuck = '0;
        repeat (3) tick();
        check("R6 flag sticky", int'(err_flag), 1);
    endtask

    task automatic t_skip_value();
        do_reset();
        ovr_en = 1'b1; ovr_val = '0;
        c_start = 1'b1; tick(); c_start = 1'b0;
        for (int v = 1; v <= 17; v++) begin
            ovr_val = W'(v % 16);
            tick();
            check("R1 sequence with wrap", int'(err_pulse), 0);
        end
        ovr_val = 4'd3;
        tick();
        check("R1 skipped value pulse", int'(err_pulse), 1);
        ovr_val = 4'd4;
        tick();
        check("R7 pulse one cycle", int'(err_pulse), 0);
        check("R6 flag held", int'(err_flag), 1);
    endtask

    task automatic t_bad_start();
        do_reset();
        ovr_en = 1'b1; ovr_val = '0;
        c_start = 1'b1; tick(); c_start = 1'b0;
        check("R3 start edge no pulse", int'(err_pulse), 0);
        ovr_val = 4'd2;
        tick();
        check("R3 wrong value after start", int'(err_pulse), 1);
    endtask

    task automatic t_idle_move();
        do_reset();
        ovr_en = 1'b1; ovr_val = '0;
        tick();
        check("R4 idle zero ok", int'(err_pulse), 0);
        ovr_val = 4'd3;
        tick();
        check("R4 idle change pulse", int'(err_pulse), 1);
    endtask

    task automatic t_missed_reset();
        do_reset();
        set_both(1'b0, 1'b1); tick(); set_both(1'b0, 1'b0);
        tick(); tick();
        c_rst = 1'b1;
        tick();
        check("R8 no compare under reset", int'(err_pulse), 0);
        c_rst = 1'b0;
        tick();
        check("R2 missed reset pulse", int'(err_pulse), 1);
    endtask

    task automatic t_overlap();
        do_reset();
        set_both(1'b1, 1'b1);
        tick();
        check("R5 overlap pulse", int'(err_pulse), 1);
        set_both(1'b0, 1'b0);
        tick();
        check("R7 overlap pulse ends", int'(err_pulse), 0);
        check("R6 flag after overlap", int'(err_flag), 1);
        rst_n = 1'b0;
        tick();
        check("R6 flag cleared by rst_n", int'(err_flag), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_unsync();
        rst_n = 1'b0; set_both(1'b0, 1'b0); ovr_en = 1'b1; ovr_val = 4'd9;
        tick();
        rst_n = 1'b1;
        tick();
        ovr_val = 4'd3;
        tick();
        check("R8 unsynced no compare", int'(err_pulse), 0);
        ovr_val = 4'd7;
        tick();
        check("R8 unsynced no compare", int'(err_pulse), 0);
        check("R8 unsynced no flag", int'(err_flag), 0);
    endtask

    initial begin
        @(negedge clk);
        t_fault_free();
        t_stuck_bit();
        t_skip_value();
        t_bad_start();
        t_idle_move();
        t_missed_reset();
        t_overlap();
        t_unsync();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule